// File: doc/BRIEF.md
# Sequential Configuration Register Loader

This block fills a small bank of 8-bit configuration registers for a four-channel pulse-width modulator, using one byte-wide data input and three pushbutton strobes. A 4-bit pointer names the register that receives the next byte. A load press stores the byte at the pointer and moves the pointer forward by one. A skip press moves the pointer forward without storing anything. Holding zero keeps the pointer at address 0. The pointer value is shown on a seven-segment display at all times, so an operator can see which register the next press will write.

Every strobe first passes through a two-flop synchronizer. An edge detector then turns each press into one internal event. The register contents leave the block as wide parallel buses for the PWM engine: one duty byte, one period byte and one phase byte per channel. One control register carries a self-clearing bit. Writing a 1 to that bit produces a single-cycle pulse that clears and aligns all channels. The interface is made of pushbuttons, not a data stream, so there is no valid/ready handshake and no back-pressure. An event that arrives is acted on in the next cycle.

Top module: `cfg_loader`

## Requirements
- R1: After reset the pointer is 0, every configuration byte is 0, `sync_pulse` is low and the display shows the digit 0.
- R2: A rising edge on `btn_load` stores `data_in` into the register at the pointer and then increments the pointer.
- R3: A rising edge on `btn_skip` increments the pointer and stores nothing.
- R4: While `btn_zero` is high after synchronization, the pointer is held at 0 and load and skip events have no effect.
- R5: If load and skip events arrive in the same cycle, the load is performed and the pointer advances by exactly one.
- R6: A press that is held produces exactly one action. The effect appears on the third rising clock edge after the strobe goes high: two synchronizer stages, then the register update.
- R7: The register map is fixed as follows. Addresses 2k and 2k+1 (k = 0..3) hold the duty and period of channel k, which appear in `duty_bus[8k+7:8k]` and `period_bus[8k+7:8k]`. Addresses 8, 9 and 10 hold the phase of channels 1, 2 and 3, which appear in `phase_bus[7:0]`, `[15:8]` and `[23:16]`.
- R8: Address 11 is the control register. Writing it with bit 3 set drives `sync_pulse` high for exactly one cycle. After that cycle, `ctrl_out` bit 3 reads 0, and the other seven bits keep the values written.
- R9: Loads to addresses 12 to 15 change no register and raise no pulse, but the pointer still advances. The pointer wraps from 15 to 0.
- R10: `seg_out` is active high, with bit 0 = segment a through bit 6 = segment g. It shows the pointer as a hex digit 0-9, A, b, C, d, E, F, using the common patterns (for example 0 -> 0x3F, 1 -> 0x06, A -> 0x77, F -> 0x71). `seg_dp` stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_in | input | 8 | Byte to store on a load press |
| btn_load | input | 1 | Load strobe, asynchronous |
| btn_skip | input | 1 | Skip strobe, asynchronous |
| btn_zero | input | 1 | Pointer clear, level, asynchronous |
| cur_addr | output | 4 | Current pointer value |
| seg_out | output | 7 | Segments g..a of the pointer digit |
| seg_dp | output | 1 | Decimal point, always off |
| duty_bus | output | 32 | Duty bytes of channels 0..3 |
| period_bus | output | 32 | Period bytes of channels 0..3 |
| phase_bus | output | 24 | Phase bytes of channels 1..3 |
| ctrl_out | output | 8 | Control register value |
| sync_pulse | output | 1 | One-cycle clear-and-align pulse |

## Verification
The first pass loads all sixteen pointer values in turn, each with a byte derived from its address. This covers every display digit and the wrap from 15 to 0. Because each stored byte is unique, any aliasing of the unmapped addresses onto real registers shows up as a wrong byte in the map. A full skip sweep follows, showing that the pointer moves while the stored bytes stay put. The remaining cases each separate one ordering rule from its alternatives:
- load and skip pressed together,
- a load pressed while zero is held,
- a strobe held for many cycles,
- a strobe sampled cycle by cycle to pin down its latency,
- a control write, where the cycles in which the pulse is high are counted.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int STB_LOAD = 0;
  localparam int STB_SKIP = 1;
  localparam int STB_ZERO = 2;
  localparam int NUM_STB  = 3;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], raw};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign level = sh_q[STAGES-1];
  assign rise  = level & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R6
endmodule

// File: rtl/addr_pointer.sv
module addr_pointer #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_evt,
  input  logic          skip_evt,
  input  logic          zero_lvl,
  output logic [AW-1:0] ptr,
  output logic          wr_en
);
  logic advance;

  assign wr_en   = load_evt & ~zero_lvl;
  assign advance = (load_evt | skip_evt) & ~zero_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (zero_lvl) ptr <= '0;
    else if (advance)  ptr <= ptr + 1'b1;
  end

  AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    zero_lvl |=> ptr == '0); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ((load_evt || skip_evt) && !zero_lvl) |=> ptr == $past(ptr) + 1'b1); // R5
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !skip_evt && !zero_lvl) |=> $stable(ptr)); // R3
endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
  parameter int DW       = 8,
  parameter int NUM_CH   = 4,
  parameter int AW       = 4,
  parameter int SYNC_BIT = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [DW-1:0]            wdata,
  output logic [NUM_CH*DW-1:0]     duty_bus,
  output logic [NUM_CH*DW-1:0]     period_bus,
  output logic [(NUM_CH-1)*DW-1:0] phase_bus,
  output logic [DW-1:0]            ctrl_out,
  output logic                     sync_pulse
);
  localparam int NUM_DATA  = 3 * NUM_CH - 1;
  localparam int CTRL_ADDR = NUM_DATA;
  localparam int NUM_REGS  = NUM_DATA + 1;
  localparam int PH_BASE   = 2 * NUM_CH;

  logic [DW-1:0] regs_q [NUM_DATA];
  logic [DW-1:0] ctrl_q;
  logic          sync_q;

  for (genvar i = 0; i < NUM_DATA; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          regs_q[i] <= '0;
      else if (we && waddr == AW'(i))      regs_q[i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sync_q <= 1'b0;
    end else if (we && waddr == AW'(CTRL_ADDR)) begin
      ctrl_q           <= wdata;
      ctrl_q[SYNC_BIT] <= 1'b0;
      sync_q           <= wdata[SYNC_BIT];
    end else begin
      sync_q <= 1'b0;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign duty_bus[c*DW +: DW]   = regs_q[2*c];
    assign period_bus[c*DW +: DW] = regs_q[2*c+1];
  end
  for (genvar p = 0; p < NUM_CH - 1; p++) begin : g_ph
    assign phase_bus[p*DW +: DW] = regs_q[PH_BASE+p];
  end

  always_comb begin
    ctrl_out           = ctrl_q;
    ctrl_out[SYNC_BIT] = sync_q;
  end
  assign sync_pulse = sync_q;

  AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |=> !sync_q); // R8
  AST_SYNC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == AW'(CTRL_ADDR) && wdata[SYNC_BIT]) |=> sync_pulse); // R8
  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr >= AW'(NUM_REGS)) |=> ($stable(duty_bus) && $stable(period_bus)
      && $stable(phase_bus) && !sync_pulse)); // R9
endmodule

// File: rtl/hex7_decoder.sv
module hex7_decoder (
  input  logic [3:0] nib,
  output logic [6:0] seg
);
  always_comb begin
    unique case (nib)
      4'h0: seg = 7'h3F;
      4'h1: seg = 7'h06;
      4'h2: seg = 7'h5B;
      4'h3: seg = 7'h4F;
      4'h4: seg = 7'h66;
      4'h5: seg = 7'h6D;
      4'h6: seg = 7'h7D;
      4'h7: seg = 7'h07;
      4'h8: seg = 7'h7F;
      4'h9: seg = 7'h6F;
      4'hA: seg = 7'h77;
      4'hB: seg = 7'h7C;
      4'hC: seg = 7'h39;
      4'hD: seg = 7'h5E;
      4'hE: seg = 7'h79;
      default: seg = 7'h71;
    endcase
  end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int DW       = 8,
  parameter int NUM_CH   = 4,
  parameter int AW       = 4,
  parameter int STAGES   = 2,
  parameter int SYNC_BIT = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DW-1:0]            data_in,
  input  logic                     btn_load,
  input  logic                     btn_skip,
  input  logic                     btn_zero,
  output logic [AW-1:0]            cur_addr,
  output logic [6:0]               seg_out,
  output logic                     seg_dp,
  output logic [NUM_CH*DW-1:0]     duty_bus,
  output logic [NUM_CH*DW-1:0]     period_bus,
  output logic [(NUM_CH-1)*DW-1:0] phase_bus,
  output logic [DW-1:0]            ctrl_out,
  output logic                     sync_pulse
);
  import cfg_loader_pkg::*;

  logic [NUM_STB-1:0] raw_vec, lvl_vec, rise_vec;
  logic [AW-1:0]      ptr;
  logic               wr_en;

  assign raw_vec[STB_LOAD] = btn_load;
  assign raw_vec[STB_SKIP] = btn_skip;
  assign raw_vec[STB_ZERO] = btn_zero;

  for (genvar s = 0; s < NUM_STB; s++) begin : g_stb
    strobe_sync #(.STAGES(STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (raw_vec[s]),
      .level (lvl_vec[s]),
      .rise  (rise_vec[s])
    );
  end

  addr_pointer #(.AW(AW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (rise_vec[STB_LOAD]),
    .skip_evt (rise_vec[STB_SKIP]),
    .zero_lvl (lvl_vec[STB_ZERO]),
    .ptr      (ptr),
    .wr_en    (wr_en)
  );

  reg_bank #(.DW(DW), .NUM_CH(NUM_CH), .AW(AW), .SYNC_BIT(SYNC_BIT)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (wr_en),
    .waddr      (ptr),
    .wdata      (data_in),
    .duty_bus   (duty_bus),
    .period_bus (period_bus),
    .phase_bus  (phase_bus),
    .ctrl_out   (ctrl_out),
    .sync_pulse (sync_pulse)
  );

  hex7_decoder u_hex (
    .nib (ptr[3:0]),
    .seg (seg_out)
  );

  assign cur_addr = ptr;
  assign seg_dp   = 1'b0;

  AST_WRITE_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cur_addr == $past(cur_addr) + 1'b1); // R2
endmodule

// File: tb/cfg_loader_bench.sv
module cfg_loader_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  data_in = '0;
  logic        btn_load = 1'b0, btn_skip = 1'b0, btn_zero = 1'b0;
  logic [3:0]  cur_addr;
  logic [6:0]  seg_out;
  logic        seg_dp;
  logic [31:0] duty_bus, period_bus;
  logic [23:0] phase_bus;
  logic [7:0]  ctrl_out;
  logic        sync_pulse;

  int n_cmp = 0, n_err = 0;
  int pulses = 0, dbl = 0;
  logic prev_sp = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_loader u_cfg_loader (
    .clk(clk), .rst_n(rst_n), .data_in(data_in),
    .btn_load(btn_load), .btn_skip(btn_skip), .btn_zero(btn_zero),
    .cur_addr(cur_addr), .seg_out(seg_out), .seg_dp(seg_dp),
    .duty_bus(duty_bus), .period_bus(period_bus), .phase_bus(phase_bus),
    .ctrl_out(ctrl_out), .sync_pulse(sync_pulse)
  );

  always @(posedge clk) begin
    if (rst_n && sync_pulse) pulses++;
    if (rst_n && sync_pulse && prev_sp) dbl++;
    prev_sp <= sync_pulse;
  end

  function automatic logic [7:0] fdat(int a);
    logic [3:0] n = 4'(a);
    return {n, ~n};
  endfunction

  function automatic logic [6:0] seg_exp(logic [3:0] n);
    case (n)
      4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
      4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
      4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
      4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic press(bit l, bit s, int hold);
    @(negedge clk);
    btn_load = l; btn_skip = s;
    repeat (hold) @(negedge clk);
    btn_load = 1'b0; btn_skip = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_map(string req);
    for (int k = 0; k < 4; k++) begin
      chk(req, duty_bus[8*k +: 8], fdat(2*k));
      chk(req, period_bus[8*k +: 8], fdat(2*k+1));
    end
    for (int j = 0; j < 3; j++) chk(req, phase_bus[8*j +: 8], fdat(8+j));
    chk(req, ctrl_out, fdat(11));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ptr", cur_addr, 0);
    chk("R1 seg", seg_out, 7'h3F);
    chk("R1 duty", duty_bus, 0);
    chk("R1 period", period_bus, 0);
    chk("R1 phase", phase_bus, 0);
    chk("R1 sync", sync_pulse, 0);

    // R2 / R10 / R9: load every address, wrap to 0
    for (int a = 0; a < 16; a++) begin
      chk("R10 seg", {seg_dp, seg_out}, {1'b0, seg_exp(4'(a))});
      data_in = fdat(a);
      press(1'b1, 1'b0, 3);
      chk("R2 ptr", cur_addr, (a + 1) % 16);
    end
    chk("R9 wrap", cur_addr, 0);
    chk("R9 no pulse", pulses, 0);
    check_map("R7 map");

    // R3: skip sweep
    for (int a = 0; a < 16; a++) begin
      data_in = 8'hEE;
      press(1'b0, 1'b1, 3);
      chk("R3 ptr", cur_addr, (a + 1) % 16);
    end
    check_map("R3 unchanged");

    // R4: zero holds pointer and blocks load
    press(1'b0, 1'b1, 3); press(1'b0, 1'b1, 3); press(1'b0, 1'b1, 3);
    chk("R3 ptr3", cur_addr, 3);
    @(negedge clk); btn_zero = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 zeroed", cur_addr, 0);
    data_in = 8'hAA;
    press(1'b1, 1'b0, 3);
    chk("R4 ptr held", cur_addr, 0);
    chk("R4 no write", duty_bus[7:0], fdat(0));
    @(negedge clk); btn_zero = 1'b0;
    repeat (4) @(negedge clk);

    // R5: load and skip together
    data_in = 8'h5C;
    press(1'b1, 1'b1, 3);
    chk("R5 ptr", cur_addr, 1);
    chk("R5 write", duty_bus[7:0], 8'h5C);
    chk("R5 neighbour", period_bus[7:0], fdat(1));

    // R6: held strobe acts once
    data_in = 8'h33;
    press(1'b1, 1'b0, 20);
    chk("R6 held ptr", cur_addr, 2);
    chk("R6 held write", period_bus[7:0], 8'h33);

    // R6: latency of three edges
    @(negedge clk); data_in = 8'h44; btn_load = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R6 before", cur_addr, 2);
    @(negedge clk);
    chk("R6 after", cur_addr, 3);
    chk("R6 data", duty_bus[15:8], 8'h44);
    btn_load = 1'b0;
    repeat (4) @(negedge clk);

    // R8: control write raises one pulse
    for (int i = 0; i < 8; i++) press(1'b0, 1'b1, 3);
    chk("R8 ptr11", cur_addr, 11);
    begin
      int p0 = pulses;
      data_in = 8'h0F;
      press(1'b1, 1'b0, 3);
      chk("R8 pulse count", pulses - p0, 1);
    end
    chk("R8 single cycle", dbl, 0);
    chk("R8 ctrl", ctrl_out, 8'h07);
    chk("R8 sync low", sync_pulse, 0);
    chk("R9 ptr12", cur_addr, 12);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule